// File: doc/BRIEF.md
# Base and Limit Address Protection Unit

This block sits between a processor's load/store path and memory and confines every user-mode access to one contiguous window of physical memory. Two privileged registers hold the window: a relocation offset (base) and a window size (limit). A user access whose virtual address is below the limit is relocated by adding the base and forwarded as a memory request. A user access at or above the limit is aborted: no memory request goes out, a fault is raised and the offending virtual address is captured for the trap handler to inspect.

Kernel-mode accesses are not checked or relocated; their virtual address is forwarded unchanged. Both registers are loaded through a small configuration port that only acts while the processor is in kernel mode, which is how the kernel installs a new window on a process switch. A user-mode attempt to load them has no effect on the registers and raises a one-cycle privilege-violation pulse. All results appear one clock after the request.

Top module: `bl_guard`

## Requirements
- R1: After reset, base and limit are both zero, `mem_valid_o`, `fault_o` and `priv_viol_o` are low and `fault_vaddr_o` is zero; a user access made before any register load therefore faults.
- R2: A user request (`kernel_i`=0) whose address is strictly below the limit produces, one cycle later, `mem_valid_o`=1, `fault_o`=0, `mem_paddr_o` = address + base (modulo 2^32) and `mem_write_o` equal to the request's write flag.
- R3: A user request whose address is greater than or equal to the limit produces, one cycle later, `fault_o`=1 and `mem_valid_o`=0.
- R4: On a fault, `fault_vaddr_o` shows the faulting virtual address from the cycle after the request and keeps it until the next fault.
- R5: A kernel request (`kernel_i`=1) produces, one cycle later, `mem_valid_o`=1, `fault_o`=0 and `mem_paddr_o` equal to the virtual address, whatever the base and limit.
- R6: With `cfg_we_i`=1 and `kernel_i`=1, `cfg_sel_i`=0 loads the base and `cfg_sel_i`=1 loads the limit from `cfg_wdata_i`; the new value governs the request presented in the next cycle, while a request in the same cycle as the load still sees the old value.
- R7: A configuration write with `kernel_i`=0 leaves base and limit unchanged, as seen through later translations.
- R8: `priv_viol_o` is high for exactly the one cycle following each user-mode configuration write attempt and low otherwise.
- R9: In a cycle after one with no request, `mem_valid_o` and `fault_o` are both low; the two are never high together.
- R10: With base 0x20000 and limit 0x10000, user address 0x0 maps to 0x20000, 0xFFFF maps to 0x2FFFF and 0x10000 faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kernel_i | input | 1 | Current privilege: 1 kernel, 0 user; applies to request and config write |
| req_valid_i | input | 1 | Access request present |
| req_vaddr_i | input | 32 | Virtual address of the access |
| req_write_i | input | 1 | 1 store, 0 load |
| cfg_we_i | input | 1 | Register load strobe |
| cfg_sel_i | input | 1 | 0 selects base, 1 selects limit |
| cfg_wdata_i | input | 32 | Value to load |
| mem_valid_o | output | 1 | Memory request issued |
| mem_paddr_o | output | 32 | Physical address of the request |
| mem_write_o | output | 1 | Store flag of the request |
| fault_o | output | 1 | Bounds violation, one cycle per faulting access |
| fault_vaddr_o | output | 32 | Last faulting virtual address |
| priv_viol_o | output | 1 | User attempted a register load |

## Verification
The bench aims at the window edge: addresses equal to limit-1, limit and limit+1, where an off-by-one compare would let the first byte past the window through or reject the last legal byte. It loads registers in the same cycle as a request and in the cycle just before one, so a design that applies a load early or a cycle late relocates with the wrong base. It issues user loads to the registers and then translates, exposing a design whose privilege gate leaks, and it drives kernel accesses far beyond the limit to catch a design that checks or relocates them. Bases near the top of the address space exercise wrap-around in the adder.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int unsigned ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef enum logic { SEL_BASE = 1'b0, SEL_LIMIT = 1'b1 } cfg_sel_e;
endpackage

// File: rtl/bl_regs.sv
module bl_regs
  import bl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  kernel_i,
  input  logic  we_i,
  input  logic  sel_i,
  input  addr_t wdata_i,
  output addr_t base_o,
  output addr_t limit_o,
  output logic  viol_o
);
  addr_t base_q, limit_q;
  logic  viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      limit_q <= '0;
      viol_q  <= 1'b0;
    end else begin
      viol_q <= we_i & ~kernel_i;
      if (we_i && kernel_i) begin
        if (cfg_sel_e'(sel_i) == SEL_BASE) base_q  <= wdata_i;
        else                               limit_q <= wdata_i;
      end
    end
  end

  assign base_o  = base_q;
  assign limit_o = limit_q;
  assign viol_o  = viol_q;

  assert_user_load_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !kernel_i) |=> ($stable(base_q) && $stable(limit_q)));
  assert_viol_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !kernel_i) |=> viol_q);
  assert_viol_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && !kernel_i) |=> !viol_q);
  assert_kernel_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kernel_i && !sel_i) |=> (base_q == $past(wdata_i)));
endmodule

// File: rtl/bl_xlate.sv
module bl_xlate
  import bl_pkg::*;
(
  input  logic  kernel_i,
  input  addr_t vaddr_i,
  input  addr_t base_i,
  input  addr_t limit_i,
  output addr_t paddr_o,
  output logic  oob_o
);
  always_comb begin
    if (kernel_i) begin
      paddr_o = vaddr_i;
      oob_o   = 1'b0;
    end else begin
      paddr_o = vaddr_i + base_i;
      oob_o   = !(vaddr_i < limit_i);
    end
  end
endmodule

// File: rtl/bl_guard.sv
module bl_guard
  import bl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kernel_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic              req_write_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_paddr_o,
  output logic              mem_write_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_vaddr_o,
  output logic              priv_viol_o
);
  addr_t base_w, limit_w, paddr_w;
  logic  oob_w;

  bl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kernel_i(kernel_i),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .base_o  (base_w),
    .limit_o (limit_w),
    .viol_o  (priv_viol_o)
  );

  bl_xlate u_xlate (
    .kernel_i(kernel_i),
    .vaddr_i (req_vaddr_i),
    .base_i  (base_w),
    .limit_i (limit_w),
    .paddr_o (paddr_w),
    .oob_o   (oob_w)
  );

  logic  valid_q, write_q, fault_q;
  addr_t paddr_q, fvaddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      write_q  <= 1'b0;
      fault_q  <= 1'b0;
      paddr_q  <= '0;
      fvaddr_q <= '0;
    end else begin
      valid_q <= req_valid_i & ~oob_w;
      fault_q <= req_valid_i & oob_w;
      if (req_valid_i && !oob_w) begin
        paddr_q <= paddr_w;
        write_q <= req_write_i;
      end
      if (req_valid_i && oob_w) fvaddr_q <= req_vaddr_i;
    end
  end

  assign mem_valid_o   = valid_q;
  assign mem_write_o   = write_q;
  assign mem_paddr_o   = paddr_q;
  assign fault_o       = fault_q;
  assign fault_vaddr_o = fvaddr_q;

  assert_user_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !kernel_i && (req_vaddr_i < limit_w)) |=>
      (mem_valid_o && !fault_o && mem_paddr_o == $past(req_vaddr_i) + $past(base_w)));
  assert_user_oob_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !kernel_i && !(req_vaddr_i < limit_w)) |=> (fault_o && !mem_valid_o));
  assert_fault_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_vaddr_o == $past(req_vaddr_i)));
  assert_kernel_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && kernel_i) |=> (mem_valid_o && mem_paddr_o == $past(req_vaddr_i)));
  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!mem_valid_o && !fault_o));
  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && fault_o));
endmodule

// File: tb/bl_guard_tb.sv
module bl_guard_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kernel = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_valid, mem_write, fault, priv_viol;
  logic [31:0] mem_paddr, fault_vaddr;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_base = '0, m_limit = '0, m_fva = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bl_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .kernel_i(kernel),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .mem_valid_o(mem_valid), .mem_paddr_o(mem_paddr), .mem_write_o(mem_write),
    .fault_o(fault), .fault_vaddr_o(fault_vaddr), .priv_viol_o(priv_viol)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_oob(input logic k, input logic [31:0] va);
    return !k && !(va < m_limit);
  endfunction

  // one cycle: drive, clock, check against model, update model
  task automatic cyc(input logic k, input logic v, input logic [31:0] va, input logic w,
                     input logic we, input logic sel, input logic [31:0] wd);
    bit oob;
    logic [31:0] pa;
    @(negedge clk);
    kernel = k; req_valid = v; req_vaddr = va; req_write = w;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    oob = is_oob(k, va);
    pa  = k ? va : va + m_base;
    @(posedge clk);
    #1;
    if (!v) begin
      chk("R9 idle valid", {31'b0, mem_valid}, 32'd0);
      chk("R9 idle fault", {31'b0, fault}, 32'd0);
    end else if (oob) begin
      m_fva = va;
      chk("R3 fault", {31'b0, fault}, 32'd1);
      chk("R3 no mem", {31'b0, mem_valid}, 32'd0);
      chk("R4 fault vaddr", fault_vaddr, m_fva);
    end else begin
      chk(k ? "R5 kernel valid" : "R2 user valid", {31'b0, mem_valid}, 32'd1);
      chk(k ? "R5 kernel paddr" : "R2 user paddr", mem_paddr, pa);
      chk("R2 write flag", {31'b0, mem_write}, {31'b0, w});
      chk("R9 no fault", {31'b0, fault}, 32'd0);
    end
    if (v && !oob) chk("R4 fault vaddr hold", fault_vaddr, m_fva);
    chk("R8 priv viol", {31'b0, priv_viol}, {31'b0, we & ~k});
    if (we && k) begin
      if (!sel) m_base = wd; else m_limit = wd;
    end
  endtask

  task automatic kload(input logic sel, input logic [31:0] d);
    cyc(1'b1, 1'b0, '0, 1'b0, 1'b1, sel, d);
  endtask

  initial begin
    repeat (CLK_PERIOD > 0 ? 200000 : 1) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    // R1 reset state
    chk("R1 valid", {31'b0, mem_valid}, 32'd0);
    chk("R1 fault", {31'b0, fault}, 32'd0);
    chk("R1 viol", {31'b0, priv_viol}, 32'd0);
    chk("R1 fvaddr", fault_vaddr, 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, '0);            // R1 zero limit faults
    cyc(1'b1, 1'b1, 32'hFFFF_FFF0, 1'b1, 1'b0, 1'b0, '0);    // R5
    // R10 example window
    kload(1'b0, 32'h2_0000);
    kload(1'b1, 32'h1_0000);
    cyc(1'b0, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, '0);
    chk("R10 low end", mem_paddr, 32'h2_0000);
    cyc(1'b0, 1'b1, 32'hFFFF, 1'b0, 1'b0, 1'b0, '0);
    chk("R10 high end", mem_paddr, 32'h2_FFFF);
    cyc(1'b0, 1'b1, 32'h1_0000, 1'b0, 1'b0, 1'b0, '0);
    chk("R10 past end", {31'b0, fault}, 32'd1);
    cyc(1'b0, 1'b1, 32'h1_0001, 1'b0, 1'b0, 1'b0, '0);
    // R7 user loads ignored
    cyc(1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 32'h9999_0000);
    cyc(1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b1, 32'h1_0000, 1'b0, 1'b0, 1'b0, '0);      // R7 limit kept
    cyc(1'b0, 1'b1, 32'h10, 1'b0, 1'b0, 1'b0, '0);          // R7 base kept
    chk("R7 base unchanged", mem_paddr, 32'h2_0010);
    // R6 same-cycle load uses old, next uses new; wrap-around base
    cyc(1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0, 32'hFFFF_F000);
    cyc(1'b0, 1'b1, 32'h2000, 1'b0, 1'b0, 1'b0, '0);
    chk("R6 new base wraps", mem_paddr, 32'h0000_1000);
    // R6: kernel load of limit together with user? mode is shared, so load then access
    kload(1'b1, 32'h100);
    cyc(1'b0, 1'b1, 32'hFF, 1'b0, 1'b0, 1'b0, '0);
    cyc(1'b0, 1'b1, 32'h100, 1'b0, 1'b0, 1'b0, '0);
    // R6 kernel request in same cycle as load sees old base (bypass anyway) then user sees new
    cyc(1'b1, 1'b1, 32'h55, 1'b0, 1'b1, 1'b0, 32'h4000);
    cyc(1'b0, 1'b1, 32'h55, 1'b1, 1'b0, 1'b0, '0);
    chk("R6 base applied next", mem_paddr, 32'h4055);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic k, v, w, we, sel;
      logic [31:0] va, wd;
      k   = ($urandom % 4) == 0;
      v   = ($urandom % 5) != 0;
      w   = $urandom;
      we  = ($urandom % 6) == 0;
      sel = $urandom;
      wd  = sel ? ($urandom % 32'h1_0000) : $urandom;
      case ($urandom % 4)
        0: va = m_limit;
        1: va = m_limit - 32'd1;
        2: va = m_limit + 32'd1;
        default: va = $urandom % (m_limit * 2 + 32'd4);
      endcase
      cyc(k, v, va, w, we, sel, wd);
    end
    cyc(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule